// File: doc/BRIEF.md
# Sixteen-of-Twenty-Five Pulse Rate Reducer

This block thins a stream of single-cycle strobes so that, of every 25 strobes presented, 16 come out and 9 are dropped. The output rate is therefore 0.64 times the input rate, a fractional division by 25/16. Placed behind a fixed divide-by-64 prescaler, the pair divides by exactly 100. The intended input strobe rate is below 50 MHz. Everything runs in one clock domain.

The reduction is built from a chain of identical swallow stages. Each stage passes four strobes and then drops the fifth. The second stage sees only the strobes that the first one let through. Every stage counter advances on the strobe that enters the stage, never on the strobe that leaves it, so a stage cannot stall on a strobe it has removed itself. The output is formed combinationally from the input strobe and the stage counters, so it adds no latency. A second output marks the strobe that closes each 25-strobe period.

Top module: `pulse_swallow_divider`

## Requirements
- R1: While `rst` is high, `pulse_out` and `cycle_done` stay low and all stage counters return to zero. The first strobe after reset is passed.
- R2: The first stage drops every fifth strobe it receives: input strobes 5, 10, 15, 20 and 25 of each period.
- R3: Counting from reset, every aligned group of 25 input strobes yields exactly 16 output strobes.
- R4: `pulse_out` is high in the same cycle as the input strobe it copies, for exactly that one cycle.
- R5: `pulse_out` is never high in a cycle in which `pulse_in` is low.
- R6: Strobes on consecutive cycles are each counted once. With back-to-back input, none is lost and none is duplicated.
- R7: `cycle_done` is high together with the 25th input strobe of each period. That strobe is dropped, and `cycle_done` rises exactly once per 25 input strobes.
- R8: Idle cycles leave the stage counters unchanged. The pass/drop pattern depends only on the ordinal of a strobe since reset, not on the gaps between strobes.
- R9: A reset in the middle of a period restarts the pattern at strobe 1. Within a period, the dropped strobe ordinals (1-based) are 5, 6, 10, 12, 15, 18, 20, 24 and 25.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | 1 | Input strobe, one cycle per event |
| pulse_out | output | 1 | Input strobe when passed, low when dropped |
| cycle_done | output | 1 | High with the strobe that closes a 25-strobe period |

## Verification
The assertions assume that `pulse_in` is a clean synchronous level, sampled once per clock, and that each high cycle is one event. They also assume that reset lasts at least one clock edge, so the counting windows they keep start from a cleared state. The stimulus changes `pulse_in` only on falling clock edges. It drives it low during most resets, but one reset is applied with the strobe held high to show that a strobe arriving during reset is ignored. The stimulus covers dense, sparse and irregular patterns, so the gap-independence of the pattern is exercised alongside back-to-back input.

// File: rtl/pswl_pkg.sv
package pswl_pkg;

  // Strobes in one full period of a chain of equal swallow stages.
  function automatic int unsigned cycle_len(int unsigned modulus, int unsigned stages);
    int unsigned r;
    r = 1;
    for (int unsigned i = 0; i < stages; i++) r = r * modulus;
    return r;
  endfunction

  // Strobes that survive all stages in one period.
  function automatic int unsigned passes_per_cycle(int unsigned modulus, int unsigned stages);
    int unsigned r;
    r = 1;
    for (int unsigned i = 0; i < stages; i++) r = r * (modulus - 1);
    return r;
  endfunction

  // Counter width for a modulo counter.
  function automatic int unsigned count_width(int unsigned modulus);
    return (modulus < 3) ? 1 : $clog2(modulus);
  endfunction

endpackage

// File: rtl/swallow_stage.sv
module swallow_stage #(
  parameter int unsigned MOD = 5,
  parameter int unsigned CW  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe_in,
  output logic          strobe_out,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] LAST = CW'(MOD - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last    = (cnt_q == LAST);
  // The strobe is dropped on the last count. The counter moves on the incoming strobe.
  assign strobe_out = strobe_in & ~at_last;
  assign count      = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= '0;
    else if (strobe_in) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/cycle_end_detect.sv
module cycle_end_detect #(
  parameter int unsigned MOD    = 5,
  parameter int unsigned STAGES = 2,
  parameter int unsigned CW     = 3
) (
  input  logic               strobe,
  input  logic [STAGES*CW-1:0] counts,
  output logic               done
);
  logic [STAGES-1:0] term;

  // The first stage sits on its last count and every later stage has just wrapped to zero.
  assign term[0] = (counts[CW-1:0] == CW'(MOD - 1));
  for (genvar g = 1; g < STAGES; g++) begin : g_zero
    assign term[g] = (counts[g*CW +: CW] == '0);
  end

  assign done = strobe & (&term);
endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider
  import pswl_pkg::*;
#(
  parameter int unsigned MOD    = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_in,
  output logic pulse_out,
  output logic cycle_done
);
  localparam int unsigned CW = count_width(MOD);

  logic [STAGES:0]        chain;
  logic [STAGES*CW-1:0]   stage_counts;
  logic                   accepted;

  assign accepted = pulse_in & ~rst;
  assign chain[0] = accepted;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    swallow_stage #(.MOD(MOD), .CW(CW)) u_stage (
      .clk       (clk),
      .rst       (rst),
      .strobe_in (chain[g]),
      .strobe_out(chain[g+1]),
      .count     (stage_counts[g*CW +: CW])
    );
  end

  cycle_end_detect #(.MOD(MOD), .STAGES(STAGES), .CW(CW)) u_end (
    .strobe(accepted),
    .counts(stage_counts),
    .done  (cycle_done)
  );

  assign pulse_out = chain[STAGES];
endmodule

// File: rtl/pswl_checker.sv
module pswl_checker
  import pswl_pkg::*;
#(
  parameter int unsigned MOD    = 5,
  parameter int unsigned STAGES = 2,
  parameter int unsigned CW     = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 pulse_in,
  input logic                 pulse_out,
  input logic                 cycle_done,
  input logic [STAGES*CW-1:0] counts_flat
);
  localparam logic [31:0] PASSES = 32'(passes_per_cycle(MOD, STAGES));
  localparam logic [31:0] PERIOD = 32'(cycle_len(MOD, STAGES));

  logic [31:0] pass_seen;
  logic [31:0] in_seen;
  logic        any_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      pass_seen <= '0;
      in_seen   <= '0;
      any_seen  <= 1'b0;
    end else begin
      if (pulse_in) any_seen <= 1'b1;
      if (cycle_done) begin
        pass_seen <= '0;
        in_seen   <= '0;
      end else begin
        if (pulse_out) pass_seen <= pass_seen + 32'd1;
        if (pulse_in)  in_seen   <= in_seen + 32'd1;
      end
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |-> (!pulse_out && !cycle_done));
  assert_first_passed_R1: assert property (@(posedge clk) disable iff (rst)
    (!any_seen && pulse_in) |-> pulse_out);
  assert_first_stage_drop_R2: assert property (@(posedge clk) disable iff (rst)
    (pulse_in && counts_flat[CW-1:0] == CW'(MOD - 1)) |-> !pulse_out);
  assert_window_count_R3: assert property (@(posedge clk) disable iff (rst)
    cycle_done |-> (pass_seen == PASSES));
  assert_out_needs_in_R5: assert property (@(posedge clk) disable iff (rst)
    pulse_out |-> pulse_in);
  assert_done_spacing_R7: assert property (@(posedge clk) disable iff (rst)
    cycle_done |-> (pulse_in && !pulse_out && in_seen == PERIOD - 32'd1));
  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (rst)
    !pulse_in |=> $stable(counts_flat));
endmodule

bind pulse_swallow_divider pswl_checker #(.MOD(MOD), .STAGES(STAGES), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pulse_in   (pulse_in),
  .pulse_out  (pulse_out),
  .cycle_done (cycle_done),
  .counts_flat(stage_counts)
);

// File: tb/test_pulse_swallow_divider.sv
module test_pulse_swallow_divider;
  localparam int CLK_PERIOD = 10;
  // 0-based ordinals inside a period that are dropped: 4,5,9,11,14,17,19,23,24 (R9)
  localparam logic [24:0] DROP_MASK = 25'h18A4A30;
  localparam int NVEC = 8;
  localparam logic [31:0] STIM [NVEC] = '{
    32'hFFFF_FFFF, 32'h5555_5555, 32'h0F0F_00FF, 32'h8000_0001,
    32'hFFFF_0000, 32'h1248_8421, 32'hDEAD_BEEF, 32'hFFFF_FFFF };
  localparam string VTAG [NVEC] = '{
    "R6", "R8", "R8", "R8", "R6", "R8", "R4", "R6" };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pulse_in = 1'b0;
  logic pulse_out;
  logic cycle_done;

  int vectors = 0;
  int fails = 0;
  int ord = 0;
  int outs = 0;
  int dones = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_swallow_divider i_pulse_swallow_divider (
    .clk(clk), .rst(rst), .pulse_in(pulse_in),
    .pulse_out(pulse_out), .cycle_done(cycle_done));

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b (ordinal %0d)", tag, what, act, exp, ord);
    end
  endtask

  task automatic step(input logic p, input string tag);
    logic eo, ed;
    @(negedge clk);
    pulse_in = p;
    #1;
    eo = p && !DROP_MASK[ord];
    ed = p && (ord == 24);
    check(pulse_out, eo, tag, "pulse_out");
    check(cycle_done, ed, "R7", "cycle_done");
    if (pulse_out === 1'b1) outs++;
    if (cycle_done === 1'b1) dones++;
    if (p) ord = (ord == 24) ? 0 : ord + 1;
  endtask

  task automatic do_reset(input logic p_during);
    @(negedge clk);
    rst = 1'b1;
    pulse_in = p_during;
    #1;
    check(pulse_out, 1'b0, "R1", "pulse_out in reset");
    check(cycle_done, 1'b0, "R1", "cycle_done in reset");
    @(negedge clk);
    rst = 1'b0;
    pulse_in = 1'b0;
    ord = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset with a strobe held high, then the first strobe passes
    do_reset(1'b1);
    step(1'b0, "R1");
    step(1'b1, "R1");
    // R2: strobes 2..4 pass, strobe 5 is dropped
    for (int i = 0; i < 4; i++) step(1'b1, "R2");

    // Table walk, continuing the sequence
    for (int v = 0; v < NVEC; v++)
      for (int b = 0; b < 32; b++) step(STIM[v][b], VTAG[v]);

    // R3/R6: 100 back-to-back strobes from reset yield 64 passes and 4 period ends
    do_reset(1'b0);
    outs = 0; dones = 0;
    for (int i = 0; i < 100; i++) step(1'b1, "R6");
    check(outs == 64, 1'b1, "R3", "64 of 100 passed");
    check(dones == 4, 1'b1, "R7", "4 period ends");

    // R3 with sparse input: 50 strobes each followed by two idle cycles
    do_reset(1'b0);
    outs = 0;
    for (int i = 0; i < 50; i++) begin
      step(1'b1, "R3");
      step(1'b0, "R8");
      step(1'b0, "R8");
    end
    check(outs == 32, 1'b1, "R3", "32 of 50 passed");

    // R9: reset in mid-period, then the pattern restarts at strobe 1
    for (int i = 0; i < 7; i++) step(1'b1, "R9");
    do_reset(1'b0);
    for (int i = 0; i < 25; i++) step(1'b1, "R9");

    step(1'b0, "R5");
    step(1'b0, "R5");
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule